// File: doc/BRIEF.md
# EISA-to-PCI I/O Forwarding Decoder

This block decides, once per expansion-bus cycle, whether an I/O access that begins on the EISA side should be passed over to the PCI side. It holds four programmable I/O windows. Each window has a base, an inclusive limit and an enable. Software-facing logic loads these registers through a plain address/data/write-enable port. The 16-bit cycle address is compared against every enabled window.

I/O maps are often too fragmented for four windows to describe. For that case, an off-chip decode input can request forwarding on its own. This input is active-low and idles high, so a pin held high by a pull-up never requests anything. It passes through a two-flop synchronizer before use.

The decision is taken on the clock edge where the cycle-start strobe is high. The block then registers three outputs: a forward flag, a window-hit flag and the index of the matching window. These outputs hold their values until the next strobe. Memory cycles are never forwarded.

Top module: `eisa_io_fwd_dec`

## Requirements
- R1: After reset, fwd_pci, fwd_hit and fwd_win are 0, and all windows are disabled. An I/O cycle with the external request idle is then not forwarded.
- R2: An enabled window matches when base <= address <= limit, with both ends inclusive. A matching I/O cycle gives fwd_pci=1, fwd_hit=1 and fwd_win set to the window index.
- R3: An address one below the base, or one above the limit, does not match that window.
- R4: A window whose enable bit is 0 never matches, whatever its base and limit.
- R5: When several enabled windows match the same address, fwd_win reports the lowest-numbered one.
- R6: An I/O cycle is forwarded (fwd_pci=1) when ext_dec_n has been held low for at least two clock edges before the strobe edge, even if no window matches. In that case fwd_hit=0 and fwd_win=0. With ext_dec_n high and no match, the cycle is not forwarded.
- R7: A memory cycle (cyc_is_io=0) gives fwd_pci=0 and fwd_hit=0, whatever the windows and the external request.
- R8: The outputs change only on the clock edge where cyc_start is high. Between strobes they hold their values even while the address, the cycle type or the external input change.
- R9: Configuration writes: cfg_addr[3:2] selects the window and cfg_addr[1:0] selects the field (0 base, 1 limit, 2 enable in cfg_wdata[0]). A write made on one edge applies to strobes from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Window index [3:2] and field [1:0] |
| cfg_wdata | input | 16 | Configuration write data |
| cyc_start | input | 1 | Cycle-start strobe, one clock per cycle |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_addr | input | 16 | Cycle I/O address |
| ext_dec_n | input | 1 | External decode request, active-low, idles high |
| fwd_pci | output | 1 | Registered forward-to-PCI decision |
| fwd_hit | output | 1 | Registered flag: a programmable window matched |
| fwd_win | output | 2 | Index of the lowest matching window |

## Verification
The assertions assume that cyc_start is a single-clock pulse. They also assume that cyc_is_io and cyc_addr are stable on the strobe edge. The external request is judged by its synchronized value, so the assertions assume ext_dec_n changes well before the strobe. The bench drives every input on the falling edge, so these assumptions hold. It also holds ext_dec_n steady for three clocks before any strobe whose result depends on it. Configuration writes are made on clocks with no strobe.

// File: rtl/io_fwd_pkg.sv
`timescale 1ns/1ps
// Package io_fwd_pkg
// Holds the configuration field codes shared by the register file and the bench-facing docs.
// Assumes the field selector is two bits wide.
package io_fwd_pkg;
    typedef enum logic [1:0] {
        FLD_BASE  = 2'd0,
        FLD_LIMIT = 2'd1,
        FLD_EN    = 2'd2,
        FLD_RSV   = 2'd3
    } cfg_field_e;
endpackage

// File: rtl/io_sync2.sv
`timescale 1ns/1ps
// Module io_sync2
// Two-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level, and that RST_VAL is its idle level.
module io_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/io_win_regs.sv
`timescale 1ns/1ps
// Module io_win_regs
// Base, limit and enable registers for NWIN I/O windows, written through an addr/data/we port.
// Assumes the address is {window index, field}; writes to the reserved field are dropped.
module io_win_regs
    import io_fwd_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int AW   = 16,
    localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDXW+1:0]            addr,
    input  logic [AW-1:0]              wdata,
    output logic [NWIN-1:0][AW-1:0]    win_base,
    output logic [NWIN-1:0][AW-1:0]    win_limit,
    output logic [NWIN-1:0]            win_en
);
    cfg_field_e           fld;
    logic [IDXW-1:0]      sel;

    // Split the configuration address into its window and field parts.
    always_comb begin
        fld = cfg_field_e'(addr[1:0]);
        sel = addr[IDXW+1:2];
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        // Hold one window's registers; reset leaves the window disabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_base[w]  <= '0;
                win_limit[w] <= '0;
                win_en[w]    <= 1'b0;
            end else if (we && (sel == IDXW'(w))) begin
                case (fld)
                    FLD_BASE:  win_base[w]  <= wdata;
                    FLD_LIMIT: win_limit[w] <= wdata;
                    FLD_EN:    win_en[w]    <= wdata[0];
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/io_win_match.sv
`timescale 1ns/1ps
// Module io_win_match
// Compares one address against every window and picks the lowest-numbered match.
// Purely combinational; assumes base <= limit for any window that is meant to match.
module io_win_match #(
    parameter int NWIN = 4,
    parameter int AW   = 16,
    localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [AW-1:0]              addr,
    input  logic [NWIN-1:0][AW-1:0]    win_base,
    input  logic [NWIN-1:0][AW-1:0]    win_limit,
    input  logic [NWIN-1:0]            win_en,
    output logic                       any_hit,
    output logic [IDXW-1:0]            hit_idx
);
    logic [NWIN-1:0] hit_vec;

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        assign hit_vec[w] = win_en[w] && (addr >= win_base[w]) && (addr <= win_limit[w]);
    end

    // Priority pick: scan downward so the lowest index wins.
    always_comb begin
        hit_idx = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDXW'(i);
        end
        any_hit = |hit_vec;
    end
endmodule

// File: rtl/eisa_io_fwd_dec.sv
`timescale 1ns/1ps
// Module eisa_io_fwd_dec
// Decides, once per EISA cycle strobe, whether an I/O cycle is forwarded to PCI.
// Sources are the programmable windows and a synchronized active-low external request.
// Assumes cyc_start is a one-clock pulse and that address and type are valid with it.
module eisa_io_fwd_dec #(
    parameter int NWIN = 4,
    parameter int AW   = 16,
    localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDXW+1:0]  cfg_addr,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             cyc_start,
    input  logic             cyc_is_io,
    input  logic [AW-1:0]    cyc_addr,
    input  logic             ext_dec_n,
    output logic             fwd_pci,
    output logic             fwd_hit,
    output logic [IDXW-1:0]  fwd_win
);
    logic [NWIN-1:0][AW-1:0] win_base;
    logic [NWIN-1:0][AW-1:0] win_limit;
    logic [NWIN-1:0]         win_en;
    logic                    any_hit;
    logic [IDXW-1:0]         hit_idx;
    logic                    ext_dec_sync_n;
    logic                    ext_req;

    io_win_regs #(.NWIN(NWIN), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .win_base  (win_base),
        .win_limit (win_limit),
        .win_en    (win_en)
    );

    io_win_match #(.NWIN(NWIN), .AW(AW)) u_match (
        .addr      (cyc_addr),
        .win_base  (win_base),
        .win_limit (win_limit),
        .win_en    (win_en),
        .any_hit   (any_hit),
        .hit_idx   (hit_idx)
    );

    io_sync2 #(.RST_VAL(1'b1)) u_ext_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_dec_n),
        .q     (ext_dec_sync_n)
    );

    assign ext_req = ~ext_dec_sync_n;

    // Capture the forwarding decision on the strobe edge and hold it until the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_pci <= 1'b0;
            fwd_hit <= 1'b0;
            fwd_win <= '0;
        end else if (cyc_start) begin
            fwd_pci <= cyc_is_io && (any_hit || ext_req);
            fwd_hit <= cyc_is_io && any_hit;
            fwd_win <= (cyc_is_io && any_hit) ? hit_idx : '0;
        end
    end
endmodule

// File: rtl/io_fwd_chk.sv
`timescale 1ns/1ps
// Module io_fwd_chk
// Property checker for eisa_io_fwd_dec, attached by bind below.
// Assumes a synchronous active-low reset; every property is disabled while reset is low.
module io_fwd_chk #(
    parameter int NWIN = 4,
    parameter int IDXW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cyc_start,
    input logic            cyc_is_io,
    input logic            ext_req,
    input logic [NWIN-1:0] win_en,
    input logic            fwd_pci,
    input logic            fwd_hit,
    input logic [IDXW-1:0] fwd_win
);
    p_mem_never_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !cyc_is_io) |=> (!fwd_pci && !fwd_hit));

    p_hold_between_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> ($stable(fwd_pci) && $stable(fwd_hit) && $stable(fwd_win)));

    p_hit_implies_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> fwd_pci);

    p_ext_forces_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && cyc_is_io && ext_req) |=> fwd_pci);

    p_idle_no_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !ext_req && (win_en == '0)) |=> !fwd_pci);

    p_no_hit_idx_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_hit |-> (fwd_win == '0));
endmodule

bind eisa_io_fwd_dec io_fwd_chk #(.NWIN(NWIN), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .cyc_is_io (cyc_is_io),
    .ext_req   (ext_req),
    .win_en    (win_en),
    .fwd_pci   (fwd_pci),
    .fwd_hit   (fwd_hit),
    .fwd_win   (fwd_win)
);

// File: tb/eisa_io_fwd_dec_tb.sv
`timescale 1ns/1ps
// Directed bench for eisa_io_fwd_dec: one task per scenario, each checking its own results.
module eisa_io_fwd_dec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic        cyc_is_io = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic        ext_dec_n = 1'b1;
    logic        fwd_pci;
    logic        fwd_hit;
    logic [1:0]  fwd_win;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    eisa_io_fwd_dec u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cyc_start(cyc_start), .cyc_is_io(cyc_is_io),
        .cyc_addr(cyc_addr), .ext_dec_n(ext_dec_n),
        .fwd_pci(fwd_pci), .fwd_hit(fwd_hit), .fwd_win(fwd_win)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check all three outputs as {fwd_pci, fwd_hit, fwd_win}.
    task automatic chk_out(input string req, input logic p, input logic h, input logic [1:0] w);
        chk(req, {fwd_pci, fwd_hit, fwd_win}, {p, h, w});
    endtask

    task automatic cfg_wr(input int win, input int fld, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {2'(win), 2'(fld)}; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_win(input int win, input logic [15:0] b, input logic [15:0] l, input logic en);
        cfg_wr(win, 0, b);
        cfg_wr(win, 1, l);
        cfg_wr(win, 2, {15'd0, en});
    endtask

    // One strobe; results sampled 1 ns after the capturing edge.
    task automatic bus_cyc(input logic io, input logic [15:0] a);
        @(negedge clk);
        cyc_start = 1'b1; cyc_is_io = io; cyc_addr = a;
        @(posedge clk);
        #1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic t_reset;
        chk_out("R1 reset outputs", 1'b0, 1'b0, 2'd0);
        bus_cyc(1'b1, 16'h0100);
        chk_out("R1 idle I/O not forwarded", 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_window;
        set_win(1, 16'h0300, 16'h031F, 1'b1);
        bus_cyc(1'b1, 16'h0300);
        chk_out("R2 R9 base hit", 1'b1, 1'b1, 2'd1);
        bus_cyc(1'b1, 16'h031F);
        chk_out("R2 limit hit", 1'b1, 1'b1, 2'd1);
        bus_cyc(1'b1, 16'h02FF);
        chk_out("R3 below base", 1'b0, 1'b0, 2'd0);
        bus_cyc(1'b1, 16'h0320);
        chk_out("R3 above limit", 1'b0, 1'b0, 2'd0);
        set_win(3, 16'hFFF0, 16'hFFFF, 1'b1);
        bus_cyc(1'b1, 16'hFFFF);
        chk_out("R2 top of space", 1'b1, 1'b1, 2'd3);
    endtask

    task automatic t_disable;
        cfg_wr(1, 2, 16'h0000);
        bus_cyc(1'b1, 16'h0310);
        chk_out("R4 disabled window", 1'b0, 1'b0, 2'd0);
        cfg_wr(1, 2, 16'h0001);
        bus_cyc(1'b1, 16'h0310);
        chk_out("R9 re-enable applies", 1'b1, 1'b1, 2'd1);
    endtask

    task automatic t_priority;
        set_win(2, 16'h0310, 16'h03FF, 1'b1);
        set_win(0, 16'h0318, 16'h0318, 1'b1);
        bus_cyc(1'b1, 16'h0318);
        chk_out("R5 three overlap", 1'b1, 1'b1, 2'd0);
        bus_cyc(1'b1, 16'h0310);
        chk_out("R5 two overlap", 1'b1, 1'b1, 2'd1);
        bus_cyc(1'b1, 16'h0350);
        chk_out("R2 single window 2", 1'b1, 1'b1, 2'd2);
    endtask

    task automatic t_ext;
        @(negedge clk); ext_dec_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_cyc(1'b1, 16'h8000);
        chk_out("R6 external forces forward", 1'b1, 1'b0, 2'd0);
        bus_cyc(1'b0, 16'h0318);
        chk_out("R7 memory cycle ignored", 1'b0, 1'b0, 2'd0);
        bus_cyc(1'b1, 16'h0350);
        chk_out("R6 external plus window", 1'b1, 1'b1, 2'd2);
        @(negedge clk); ext_dec_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_cyc(1'b1, 16'h8000);
        chk_out("R6 external idle", 1'b0, 1'b0, 2'd0);
        bus_cyc(1'b0, 16'h0300);
        chk_out("R7 memory in window", 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_hold;
        bus_cyc(1'b1, 16'h0350);
        @(negedge clk);
        cyc_addr = 16'h8000; cyc_is_io = 1'b0; ext_dec_n = 1'b0;
        repeat (5) @(negedge clk);
        chk_out("R8 hold without strobe", 1'b1, 1'b1, 2'd2);
        ext_dec_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_disable();
        t_priority();
        t_ext();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule